// File: doc/BRIEF.md
# Regulator Fault Supervisor and Hiccup Sequencer

This block is the digital supervisor of a step-down switching regulator. It decides when the power switch may conduct, when the soft-start ramp charges or is discharged, when power-good is released, and what caused the most recent shutdown. Every input is a synchronous digital flag. The block samples them on each clock. A strobe marks the last clock of every switching period. The analog comparators, the ramp generator, the PWM comparator and the gate driver are outside the block.

The controller has five states. In `ST_OFF` the switch is off and the ramp is held discharged. `ST_SOFTSTART` charges the ramp and permits switching once the ramp passes the switching level. `ST_RUN` is normal regulation. `ST_FAULT_WAIT` is the idle hiccup interval after an overcurrent or undervoltage shutdown. `ST_THERMAL_WAIT` holds the regulator off while the die is hot.

The transitions are as follows:
- power-up: `ST_OFF` to `ST_SOFTSTART`
- ramp at the power-good level: `ST_SOFTSTART` to `ST_RUN`
- overcurrent overflow: `ST_SOFTSTART` or `ST_RUN` to `ST_FAULT_WAIT`
- undervoltage: `ST_RUN` to `ST_FAULT_WAIT`
- hiccup expiry: `ST_FAULT_WAIT` to `ST_OFF`
- over-temperature: any powered state to `ST_THERMAL_WAIT`
- cool-down: `ST_THERMAL_WAIT` to `ST_SOFTSTART`
- power loss: any state to `ST_OFF`

Top module: `reg_fault_seq`

## Requirements
- R1: While reset is asserted, all of the following hold, whatever the inputs: the state is `ST_OFF`, `sw_permit`, `ss_run` and `pg_out` are 0, and `fault_code` is 0.
- R2: From `ST_OFF`, with `bias_ok`, `enable` high and `over_temp` low, the block enters `ST_SOFTSTART` on the next clock and drives `ss_run` high. In soft-start, `sw_permit` stays 0 while `ramp_at_sw` is low.
- R3: An `oc_trip` during a permitted on-time forces `sw_permit` low in the same clock. It stays low for the rest of that switching period, even if `oc_trip` drops. It may rise again on the first clock after the `period_end` strobe.
- R4: A period counts as an overcurrent period if `oc_trip` is seen while switching is permitted. When OC_LIMIT (8) consecutive periods are overcurrent periods, the block enters `ST_FAULT_WAIT` at the end of the last one, with `fault_code` = 1. A period without overcurrent clears the count.
- R5: `uv_trip` high in `ST_RUN` moves the block to `ST_FAULT_WAIT` with `fault_code` = 2.
- R6: In `ST_FAULT_WAIT`, `sw_permit` and `pg_out` are 0. `ss_run` is low for one clock on entry and after each `ramp_done` pulse, and high otherwise. On the HICCUP_PERIODS-th (4th) `ramp_done` pulse the block goes to `ST_OFF` and from there retries soft-start.
- R7: `over_temp` high while powered moves the block to `ST_THERMAL_WAIT` on the next clock with `fault_code` = 3 and `ss_run` low. The block leaves for `ST_SOFTSTART` on the clock after `over_temp` falls.
- R8: `bias_ok` or `enable` low moves the block to `ST_OFF` on the next clock, so switching stops and the ramp discharges. This takes priority over every fault and leaves `fault_code` unchanged. The remaining priority order is thermal, then overcurrent, then undervoltage.
- R9: `ST_SOFTSTART` moves to `ST_RUN` when `ramp_at_pg` is high. `fault_code` becomes 0 on that transition.
- R10: `pg_out` is high only in `ST_RUN` while `enable`, `bias_ok` and `out_in_window` are all high. It reacts in the same clock to those inputs.
- R11: An overcurrent overflow that completes during `ST_SOFTSTART` also leads to `ST_FAULT_WAIT` with `fault_code` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_end | input | 1 | High on the last clock of each switching period |
| bias_ok | input | 1 | Bias supply above its power-on threshold |
| enable | input | 1 | Regulator enable |
| oc_trip | input | 1 | Switch current above the limit |
| uv_trip | input | 1 | Feedback below the undervoltage level |
| over_temp | input | 1 | Die over temperature, with external hysteresis |
| out_in_window | input | 1 | Output within the power-good window |
| ramp_done | input | 1 | One-clock pulse when the soft-start ramp reaches its top |
| ramp_at_sw | input | 1 | Ramp above the switching-enable level |
| ramp_at_pg | input | 1 | Ramp above the power-good level |
| sw_permit | output | 1 | Switch may conduct |
| ss_run | output | 1 | 1 charges the ramp, 0 discharges it |
| pg_out | output | 1 | Power good |
| fault_code | output | 2 | Last fault: 0 none, 1 overcurrent, 2 undervoltage, 3 thermal |

## Verification
The hardest situation to reach is an overcurrent overflow inside soft-start. It needs eight consecutive overcurrent periods, all of them between the ramp's switching level and its power-good level. The bench therefore uses a ramp model whose climb is longer than eight periods and holds `oc_trip` high from power-up.

The hiccup interval is reached only after a full overflow, so a directed phase builds one. It first sends seven-period bursts separated by one clean period, then an eight-period burst. It then counts the `ramp_done` pulses seen in the wait state.

Random phases then mix enable and bias drops, thermal episodes and overcurrent bursts. They are compared every clock against a reference model.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [2:0] {
        ST_OFF          = 3'd0,
        ST_SOFTSTART    = 3'd1,
        ST_RUN          = 3'd2,
        ST_FAULT_WAIT   = 3'd3,
        ST_THERMAL_WAIT = 3'd4
    } rfs_state_e;

    typedef enum logic [1:0] {
        FC_NONE        = 2'd0,
        FC_OVERCURRENT = 2'd1,
        FC_UNDERVOLT   = 2'd2,
        FC_THERMAL     = 2'd3
    } rfs_fault_e;

endpackage

// File: rtl/rfs_oc_guard.sv
// Per-period overcurrent cut-off and consecutive-period counter.
module rfs_oc_guard #(
    parameter int OC_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic on_window,
    input  logic oc_trip,
    input  logic period_end,
    output logic cut_q,
    output logic overflow
);
    localparam int CW = (OC_LIMIT > 1) ? $clog2(OC_LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(OC_LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          hit;
    logic          had_oc;

    assign hit      = oc_trip && on_window;
    assign had_oc   = cut_q || hit;
    assign overflow = active && period_end && had_oc && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cut_q <= 1'b0;
            cnt_q <= '0;
        end else if (!active) begin
            cut_q <= 1'b0;
            cnt_q <= '0;
        end else if (period_end) begin
            cut_q <= 1'b0;
            if (!had_oc || overflow) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cut_q <= had_oc;
        end
    end
endmodule

// File: rtl/rfs_hiccup_timer.sv
// Counts dummy soft-start periods during the fault wait.
module rfs_hiccup_timer #(
    parameter int PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    input  logic arm,
    input  logic ramp_done,
    output logic restart_q,
    output logic expired
);
    localparam int PW = (PERIODS > 1) ? $clog2(PERIODS) : 1;
    localparam logic [PW-1:0] LAST = PW'(PERIODS - 1);

    logic [PW-1:0] per_q;

    assign expired = waiting && ramp_done && (per_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q     <= '0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= arm || (waiting && ramp_done);
            if (arm || !waiting) begin
                per_q <= '0;
            end else if (ramp_done) begin
                per_q <= per_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/reg_fault_seq.sv
module reg_fault_seq
    import rfs_pkg::*;
#(
    parameter int OC_LIMIT       = 8,
    parameter int HICCUP_PERIODS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       period_end,
    input  logic       bias_ok,
    input  logic       enable,
    input  logic       oc_trip,
    input  logic       uv_trip,
    input  logic       over_temp,
    input  logic       out_in_window,
    input  logic       ramp_done,
    input  logic       ramp_at_sw,
    input  logic       ramp_at_pg,
    output logic       sw_permit,
    output logic       ss_run,
    output logic       pg_out,
    output logic [1:0] fault_code
);
    rfs_state_e state_q, state_d;
    rfs_fault_e code_q, code_d;

    logic powered;
    logic active;
    logic on_window;
    logic pg_base;
    logic oc_cut;
    logic oc_overflow;
    logic fw_wait;
    logic fw_arm;
    logic fw_restart;
    logic fw_expired;

    assign powered = bias_ok && enable;
    assign active  = (state_q == ST_SOFTSTART) || (state_q == ST_RUN);
    assign fw_wait = (state_q == ST_FAULT_WAIT);
    assign fw_arm  = (state_d == ST_FAULT_WAIT) && !fw_wait;

    rfs_oc_guard #(.OC_LIMIT(OC_LIMIT)) u_oc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .on_window (on_window),
        .oc_trip   (oc_trip),
        .period_end(period_end),
        .cut_q     (oc_cut),
        .overflow  (oc_overflow)
    );

    rfs_hiccup_timer #(.PERIODS(HICCUP_PERIODS)) u_hiccup (
        .clk      (clk),
        .rst_n    (rst_n),
        .waiting  (fw_wait),
        .arm      (fw_arm),
        .ramp_done(ramp_done),
        .restart_q(fw_restart),
        .expired  (fw_expired)
    );

    // State and fault-cause registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            code_q  <= FC_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Transitions, in priority order: power loss, thermal, overcurrent, undervoltage
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        if (!powered) begin
            state_d = ST_OFF;
        end else if (over_temp) begin
            state_d = ST_THERMAL_WAIT;
            code_d  = FC_THERMAL;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_SOFTSTART;
                ST_SOFTSTART: begin
                    if (oc_overflow) begin
                        state_d = ST_FAULT_WAIT;
                        code_d  = FC_OVERCURRENT;
                    end else if (ramp_at_pg) begin
                        state_d = ST_RUN;
                        code_d  = FC_NONE;
                    end
                end
                ST_RUN: begin
                    if (oc_overflow) begin
                        state_d = ST_FAULT_WAIT;
                        code_d  = FC_OVERCURRENT;
                    end else if (uv_trip) begin
                        state_d = ST_FAULT_WAIT;
                        code_d  = FC_UNDERVOLT;
                    end
                end
                ST_FAULT_WAIT: begin
                    if (fw_expired) state_d = ST_OFF;
                end
                ST_THERMAL_WAIT: state_d = ST_SOFTSTART;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Per-state outputs
    always_comb begin
        ss_run    = 1'b0;
        on_window = 1'b0;
        pg_base   = 1'b0;
        unique case (state_q)
            ST_OFF:          ss_run = 1'b0;
            ST_SOFTSTART: begin
                ss_run    = 1'b1;
                on_window = ramp_at_sw;
            end
            ST_RUN: begin
                ss_run    = 1'b1;
                on_window = 1'b1;
                pg_base   = 1'b1;
            end
            ST_FAULT_WAIT:   ss_run = !fw_restart;
            ST_THERMAL_WAIT: ss_run = 1'b0;
            default:         ss_run = 1'b0;
        endcase
    end

    assign sw_permit  = on_window && !oc_cut && !oc_trip;
    assign pg_out     = pg_base && powered && out_in_window;
    assign fault_code = code_q;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker
    import rfs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bias_ok,
    input logic       enable,
    input logic       oc_trip,
    input logic       over_temp,
    input logic       out_in_window,
    input logic       ramp_at_sw,
    input logic       sw_permit,
    input logic       pg_out,
    input logic [1:0] fault_code,
    input rfs_state_e state
);
    p_nosw_ramp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOFTSTART && !ramp_at_sw) |-> !sw_permit);

    p_oc_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> !sw_permit);

    p_fw_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT_WAIT) |-> (!sw_permit && !pg_out));

    p_thermal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_ok && enable && over_temp) |=>
            (state == ST_THERMAL_WAIT && fault_code == 2'd3));

    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bias_ok || !enable) |=> (state == ST_OFF && !sw_permit));

    p_code_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $past(state) == ST_SOFTSTART) |-> (fault_code == 2'd0));

    p_pg_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !pg_out);

    p_pg_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pg_out |-> (state == ST_RUN && out_in_window));
endmodule

bind reg_fault_seq rfs_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bias_ok      (bias_ok),
    .enable       (enable),
    .oc_trip      (oc_trip),
    .over_temp    (over_temp),
    .out_in_window(out_in_window),
    .ramp_at_sw   (ramp_at_sw),
    .sw_permit    (sw_permit),
    .pg_out       (pg_out),
    .fault_code   (fault_code),
    .state        (state_q)
);

// File: tb/reg_fault_seq_test.sv
module reg_fault_seq_test;
    localparam int PER = 4;
    localparam int TOP = 60;
    localparam int SWL = 4;
    localparam int PGL = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic i_pend = 0, i_bias = 0, i_en = 0, i_oc = 0, i_uv = 0, i_hot = 0;
    logic i_win = 0, i_rdone = 0, i_rsw = 0, i_rpg = 0;
    logic sw_permit, ss_run, pg_out;
    logic [1:0] fault_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_s = 0, m_prev = 0, m_cnt = 0, m_per = 0, m_code = 0;
    bit m_cut = 0, m_rst = 0;
    int lvl = 0, pcnt = 0;

    always #2.5 clk = ~clk;

    reg_fault_seq uut (
        .clk(clk), .rst_n(rst_n), .period_end(i_pend), .bias_ok(i_bias),
        .enable(i_en), .oc_trip(i_oc), .uv_trip(i_uv), .over_temp(i_hot),
        .out_in_window(i_win), .ramp_done(i_rdone), .ramp_at_sw(i_rsw),
        .ramp_at_pg(i_rpg), .sw_permit(sw_permit), .ss_run(ss_run),
        .pg_out(pg_out), .fault_code(fault_code)
    );

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit p_sw();
        return (((m_s == 1) && i_rsw) || (m_s == 2)) && !m_cut && !i_oc;
    endfunction
    function automatic bit p_ss();
        return (m_s == 1) || (m_s == 2) || ((m_s == 3) && !m_rst);
    endfunction
    function automatic bit p_pg();
        return (m_s == 2) && i_en && i_bias && i_win;
    endfunction

    // Reference step for the clock edge that just passed
    task automatic model_step();
        int  s   = m_s;
        bit  onw = ((s == 1) && i_rsw) || (s == 2);
        bit  act = (s == 1) || (s == 2);
        bit  had = m_cut || (i_oc && onw);
        bit  ocf = act && i_pend && had && (m_cnt == 7);
        bit  hex = (s == 3) && i_rdone && (m_per == 3);
        int  n;
        if (!i_bias || !i_en) n = 0;
        else begin
            case (s)
                0: n = i_hot ? 4 : 1;
                1: n = i_hot ? 4 : (ocf ? 3 : (i_rpg ? 2 : 1));
                2: n = i_hot ? 4 : (ocf ? 3 : (i_uv ? 3 : 2));
                3: n = i_hot ? 4 : (hex ? 0 : 3);
                default: n = i_hot ? 4 : 1;
            endcase
            if (n == 4) m_code = 3;
            else if (ocf) m_code = 1;
            else if (s == 2 && n == 3) m_code = 2;
            else if (s == 1 && n == 2) m_code = 0;
        end
        if (!act) begin m_cut = 0; m_cnt = 0; end
        else if (i_pend) begin m_cut = 0; m_cnt = (had && !ocf) ? m_cnt + 1 : 0; end
        else m_cut = had;
        if (n == 3 && s != 3) begin m_per = 0; m_rst = 1; end
        else if (s == 3) begin m_per = i_rdone ? m_per + 1 : m_per; m_rst = i_rdone; end
        else begin m_per = 0; m_rst = 0; end
        m_prev = s;
        m_s = n;
    endtask

    task automatic tick();
        bit ssp;
        @(negedge clk);
        model_step();
        chk("R3 sw_permit", sw_permit, p_sw());
        chk("R6 ss_run", ss_run, p_ss());
        chk("R10 pg_out", pg_out, p_pg());
        chk("R4 fault_code", fault_code, m_code);
        ssp = p_ss();
        if (!ssp) begin lvl = 0; i_rdone = 0; end
        else if (lvl < TOP) begin lvl++; i_rdone = (lvl == TOP); end
        else i_rdone = 0;
        i_rsw = (lvl >= SWL);
        i_rpg = (lvl >= PGL);
        pcnt = (pcnt + 1) % PER;
        i_pend = (pcnt == PER - 1);
    endtask

    task automatic finish_period();
        bit was;
        do begin was = i_pend; tick(); end while (!was);
    endtask

    task automatic wait_state(int st, string tag);
        int k = 0;
        while (m_s != st && k < 3000) begin tick(); k++; end
        chk(tag, m_s, st);
    endtask

    initial begin
        int pulses;
        int oc_mode;
        void'($urandom(32'd4417));
        i_bias = 1; i_en = 1; i_win = 1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset sw", sw_permit, 0);
        chk("R1 reset ss", ss_run, 0);
        chk("R1 reset pg", pg_out, 0);
        chk("R1 reset code", fault_code, 0);
        rst_n = 1;

        // R2: soft-start begins, no switching below the ramp level
        tick();
        #1;
        chk("R2 ss_run after power-up", ss_run, 1);
        chk("R2 no switching below ramp level", sw_permit, 0);
        while (!(m_s == 1 && i_rsw)) tick();
        #1;
        chk("R2 switching above ramp level", sw_permit, 1);
        wait_state(2, "R9 reach run");
        #1;
        chk("R9 code cleared in run", fault_code, 0);
        chk("R10 pg released", pg_out, 1);

        // R3: cut for the rest of the period
        finish_period();
        i_oc = 1;
        #1;
        chk("R3 immediate cut", sw_permit, 0);
        tick();
        i_oc = 0;
        #1;
        chk("R3 cut held", sw_permit, 0);
        finish_period();
        #1;
        chk("R3 resume next period", sw_permit, 1);

        // R4: seven-period bursts do not trip, eight do
        finish_period();
        for (int b = 0; b < 2; b++) begin
            i_oc = 1;
            repeat (7) finish_period();
            i_oc = 0;
            finish_period();
        end
        #1;
        chk("R4 no trip below limit", fault_code, 0);
        chk("R4 still regulating", pg_out, 1);
        i_oc = 1;
        repeat (8) finish_period();
        #1;
        chk("R4 overcurrent code", fault_code, 1);
        chk("R6 no switching in wait", sw_permit, 0);
        i_oc = 0;

        // R6: four dummy ramp periods before retry
        pulses = 0;
        while (m_s != 0 && pulses < 10) begin
            if (m_s == 3 && i_rdone) pulses++;
            tick();
        end
        chk("R6 dummy periods", pulses, 4);
        chk("R6 code held until run", fault_code, 1);
        wait_state(2, "R9 retry reaches run");
        #1;
        chk("R9 code cleared on retry", fault_code, 0);

        // R5: undervoltage
        i_uv = 1;
        tick();
        i_uv = 0;
        #1;
        chk("R5 undervoltage code", fault_code, 2);
        chk("R6 ramp discharged on entry", ss_run, 0);
        wait_state(2, "R5 recovers");

        // R7: thermal
        i_hot = 1;
        tick();
        #1;
        chk("R7 thermal code", fault_code, 3);
        chk("R7 ramp discharged", ss_run, 0);
        repeat (5) tick();
        i_hot = 0;
        tick();
        #1;
        chk("R7 restart after cool-down", ss_run, 1);
        wait_state(2, "R7 recovers");

        // R10 and R8: enable drop, then power loss with simultaneous heat
        i_en = 0;
        #1;
        chk("R10 pg drops with enable", pg_out, 0);
        tick();
        #1;
        chk("R8 off after enable low", ss_run, 0);
        i_en = 1;
        wait_state(2, "R8 recovers");
        i_bias = 0; i_hot = 1;
        tick();
        #1;
        chk("R8 power loss beats thermal", fault_code, 0);
        chk("R8 no switching", sw_permit, 0);
        i_bias = 1; i_hot = 0;

        // R11: overflow inside soft-start
        i_oc = 1;
        wait_state(3, "R11 reach fault wait");
        chk("R11 came from soft-start", m_prev, 1);
        #1;
        chk("R11 overcurrent code", fault_code, 1);
        i_oc = 0;
        wait_state(2, "R11 recovers");

        // Random mix
        oc_mode = 0;
        for (int c = 0; c < 12000; c++) begin
            tick();
            i_en   = ($urandom % 400) != 0;
            i_bias = ($urandom % 700) != 0;
            if (i_hot) i_hot = ($urandom % 20) != 0;
            else       i_hot = ($urandom % 900) == 0;
            i_uv  = ($urandom % 300) == 0;
            i_win = ($urandom % 10) != 0;
            if ($urandom % 60 == 0) oc_mode = $urandom % 3;
            i_oc = (oc_mode == 2) || (oc_mode == 1 && ($urandom % 3) == 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule